// File: doc/BRIEF.md
# Row-Hit-First Request Picker

This block chooses which entry of a memory controller request queue is moved to the head of that queue. The queue holds up to N requests in age order, with entry 0 the oldest. Each entry has a valid bit, a target row, a rank and a bank within that rank. Per-bank state comes from outside the block: the row held open in each bank, and the time at which each bank becomes free. The block also receives the current time and a mask of the banks that become free earliest, which a companion block computes.

Two policies are supported. Under plain first-come-first-served the head stays where it is. Under row-hit-first the oldest valid entry that targets its bank's open row wins. When no entry hits an open row, the block picks the oldest valid entry whose bank is already free, or whose bank is one of the earliest-free banks. The earliest-bank mask is requested only in that no-hit case. A single-cycle start pulse launches a pick. One cycle later the registered index, a found flag, a row-hit flag and a done strobe appear. A read queue and a write queue each use their own instance.

Top module: `rowhit_picker`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, pick_idx_o, pick_found_o, pick_hit_o and done_o are all 0.
- R2: done_o is 1 in exactly the cycle after a cycle with start_i high. The pick outputs change only in that cycle and hold their values while start_i stays low.
- R3: When policy_i is 0 (first-come-first-served), the result is index 0, with found equal to the valid bit of entry 0 and the hit flag 0.
- R4: When policy_i is 1 (row-hit-first), the lowest-index valid entry whose row equals the open row of its bank is chosen, and the hit flag is 1.
- R5: Under row-hit-first, a row hit at any position wins over an older entry that is only bank-ready.
- R6: With no row hit, the lowest-index valid entry whose bank free time is less than or equal to now_i is eligible. The comparison is unsigned, and an equal time counts as free.
- R7: With no row hit, an entry whose flat bank bit is set in early_mask_i is eligible in the same lowest-index-first order as the bank-ready entries.
- R8: early_req_o is high only in a start cycle, under row-hit-first, when no valid entry hits an open row.
- R9: The flat bank index is rank × BANKS_PER_RANK + bank. Entry i's rank occupies ent_rank_i[i*RANK_W +: RANK_W], its bank ent_bank_i[i*BANK_W +: BANK_W] and its row ent_row_i[i*ROW_W +: ROW_W]. Bank b's open row is open_row_i[b*ROW_W +: ROW_W] and its free time is free_at_i[b*TIME_W +: TIME_W].
- R10: When no entry qualifies under row-hit-first, the result is index 0 with found 0 and hit 0.
- R11: Entries whose valid bit is 0 are never picked by the row-hit or fallback rules, whatever their row and bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse that launches a pick |
| policy_i | input | 1 | 0 = first-come-first-served, 1 = row-hit-first |
| ent_valid_i | input | N | Per-entry valid bits, bit 0 oldest |
| ent_row_i | input | N*ROW_W | Per-entry target row |
| ent_rank_i | input | N*RANK_W | Per-entry rank |
| ent_bank_i | input | N*BANK_W | Per-entry bank within the rank |
| open_row_i | input | NB*ROW_W | Open row of each flat bank |
| free_at_i | input | NB*TIME_W | Free time of each flat bank |
| now_i | input | TIME_W | Current time |
| early_mask_i | input | NB | Earliest-free banks, one bit per flat bank |
| early_req_o | output | 1 | Request for the earliest-bank mask |
| pick_idx_o | output | IDX_W | Index of the entry to promote |
| pick_found_o | output | 1 | An entry qualified |
| pick_hit_o | output | 1 | The pick is a row hit |
| done_o | output | 1 | Result valid strobe |

## Verification
A wrong per-entry hit or eligibility flag shows up one cycle after start as a wrong index or a wrong hit flag, because the selection is one parallel step followed by one register. A mistake in the flat-bank arithmetic sends an entry to another bank's open row or free time, which flips a hit into a miss. The table cases give each entry its own flat bank, and a directed case puts different open rows on the banks that a wrong mapping would reach. A wrong mask request can be seen in the start cycle itself, before the result is registered.

// File: rtl/rowhit_picker_pkg.sv
package rowhit_picker_pkg;

  // Flat bank number across ranks: rank-major, bank within rank minor.
  function automatic int unsigned flat_bank(input int unsigned rank,
                                            input int unsigned bank,
                                            input int unsigned per_rank);
    return rank * per_rank + bank;
  endfunction

  // Bank is usable now when its free time is not later than now (unsigned).
  function automatic logic bank_free_now(input logic [63:0] free_at,
                                         input logic [63:0] now);
    return free_at <= now;
  endfunction

endpackage

// File: rtl/rowhit_entry_eval.sv
module rowhit_entry_eval
  import rowhit_picker_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int TIME_W  = 16,
  parameter int RANK_W  = 1,
  parameter int BANK_W  = 3,
  parameter int BPR     = 8,
  parameter int NB      = 16
) (
  input  logic                 valid_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic [RANK_W-1:0]    rank_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [NB*ROW_W-1:0]  open_row_i,
  input  logic [NB*TIME_W-1:0] free_at_i,
  input  logic [TIME_W-1:0]    now_i,
  input  logic [NB-1:0]        early_mask_i,
  output logic                 hit_o,
  output logic                 elig_o
);

  int unsigned fb;
  logic        in_range;
  int unsigned fb_safe;
  logic [ROW_W-1:0]  bank_row;
  logic [TIME_W-1:0] bank_free;

  always_comb begin
    fb        = flat_bank(32'(rank_i), 32'(bank_i), BPR);
    in_range  = fb < NB;
    fb_safe   = in_range ? fb : 0;
    bank_row  = open_row_i[fb_safe*ROW_W +: ROW_W];
    bank_free = free_at_i[fb_safe*TIME_W +: TIME_W];
    hit_o     = valid_i && in_range && (bank_row == row_i);
    elig_o    = valid_i && in_range &&
                (bank_free_now(64'(bank_free), 64'(now_i)) || early_mask_i[fb_safe]);
  end

endmodule

// File: rtl/rowhit_prio_enc.sv
module rowhit_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  // Lowest index (oldest) wins.
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o   = |req_i;
    grant_o = req_i & (~req_i + N'(1));
  end

endmodule

// File: rtl/rowhit_picker.sv
module rowhit_picker
  import rowhit_picker_pkg::*;
#(
  parameter int N      = 8,
  parameter int RANKS  = 2,
  parameter int BPR    = 8,
  parameter int ROW_W  = 8,
  parameter int TIME_W = 16,
  localparam int NB     = RANKS * BPR,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BPR > 1) ? $clog2(BPR) : 1,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 policy_i,
  input  logic [N-1:0]         ent_valid_i,
  input  logic [N*ROW_W-1:0]   ent_row_i,
  input  logic [N*RANK_W-1:0]  ent_rank_i,
  input  logic [N*BANK_W-1:0]  ent_bank_i,
  input  logic [NB*ROW_W-1:0]  open_row_i,
  input  logic [NB*TIME_W-1:0] free_at_i,
  input  logic [TIME_W-1:0]    now_i,
  input  logic [NB-1:0]        early_mask_i,
  output logic                 early_req_o,
  output logic [IDX_W-1:0]     pick_idx_o,
  output logic                 pick_found_o,
  output logic                 pick_hit_o,
  output logic                 done_o
);

  logic [N-1:0]     hit_vec;
  logic [N-1:0]     elig_vec;
  logic [N-1:0]     hit_grant;
  logic [N-1:0]     elig_grant;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] elig_idx;
  logic             hit_any;
  logic             elig_any;

  for (genvar g = 0; g < N; g++) begin : g_ent
    rowhit_entry_eval #(
      .ROW_W(ROW_W), .TIME_W(TIME_W), .RANK_W(RANK_W),
      .BANK_W(BANK_W), .BPR(BPR), .NB(NB)
    ) u_eval (
      .valid_i      (ent_valid_i[g]),
      .row_i        (ent_row_i[g*ROW_W +: ROW_W]),
      .rank_i       (ent_rank_i[g*RANK_W +: RANK_W]),
      .bank_i       (ent_bank_i[g*BANK_W +: BANK_W]),
      .open_row_i   (open_row_i),
      .free_at_i    (free_at_i),
      .now_i        (now_i),
      .early_mask_i (early_mask_i),
      .hit_o        (hit_vec[g]),
      .elig_o       (elig_vec[g])
    );
  end

  rowhit_prio_enc #(.N(N), .IDX_W(IDX_W)) u_hit_enc (
    .req_i (hit_vec), .grant_o (hit_grant), .idx_o (hit_idx), .any_o (hit_any)
  );

  rowhit_prio_enc #(.N(N), .IDX_W(IDX_W)) u_elig_enc (
    .req_i (elig_vec), .grant_o (elig_grant), .idx_o (elig_idx), .any_o (elig_any)
  );

  // Mask is only wanted when the row-hit scan came up empty.
  assign early_req_o = start_i && policy_i && !hit_any;

  logic [IDX_W-1:0] nxt_idx;
  logic             nxt_found;
  logic             nxt_hit;

  always_comb begin
    nxt_idx   = '0;
    nxt_found = 1'b0;
    nxt_hit   = 1'b0;
    if (!policy_i) begin
      nxt_found = ent_valid_i[0];
    end else if (hit_any) begin
      nxt_idx   = hit_idx;
      nxt_found = 1'b1;
      nxt_hit   = 1'b1;
    end else if (elig_any) begin
      nxt_idx   = elig_idx;
      nxt_found = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pick_idx_o   <= '0;
      pick_found_o <= 1'b0;
      pick_hit_o   <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        pick_idx_o   <= nxt_idx;
        pick_found_o <= nxt_found;
        pick_hit_o   <= nxt_hit;
      end
    end
  end

  // Assertions
  a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  a_r2_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(pick_idx_o) && $stable(pick_found_o) && $stable(pick_hit_o) && !done_o));
  a_r3_fcfs_head: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !policy_i) |=> (pick_idx_o == '0 && !pick_hit_o));
  a_r4_hit_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_grant) && $onehot0(elig_grant));
  a_r5_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && policy_i && hit_any) |=> (pick_hit_o && pick_found_o && pick_idx_o == $past(hit_idx)));
  a_r8_mask_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    early_req_o |-> (start_i && policy_i && hit_vec == '0));
  a_r10_none_gives_head: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !pick_found_o) |-> (pick_idx_o == '0 && !pick_hit_o));
  a_r11_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_vec | elig_vec) & ~ent_valid_i) == '0);

endmodule

// File: tb/rowhit_picker_bench.sv
module rowhit_picker_bench;

  localparam int N = 8, RANKS = 2, BPR = 8, ROW_W = 8, TIME_W = 16;
  localparam int NB = RANKS * BPR, RANK_W = 1, BANK_W = 3, IDX_W = 3;
  localparam logic [TIME_W-1:0] NOW = 16'd1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, policy = 1'b0;
  logic [N-1:0]         valid = '0;
  logic [N*ROW_W-1:0]   rows = '0;
  logic [N*RANK_W-1:0]  ranks = '0;
  logic [N*BANK_W-1:0]  banks = '0;
  logic [NB*ROW_W-1:0]  open_rows = '1;
  logic [NB*TIME_W-1:0] free_at = '1;
  logic [TIME_W-1:0]    now = NOW;
  logic [NB-1:0]        emask = '0;
  logic                 early_req, found, hit, done;
  logic [IDX_W-1:0]     idx;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  rowhit_picker u_rowhit_picker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .policy_i(policy),
    .ent_valid_i(valid), .ent_row_i(rows), .ent_rank_i(ranks), .ent_bank_i(banks),
    .open_row_i(open_rows), .free_at_i(free_at), .now_i(now), .early_mask_i(emask),
    .early_req_o(early_req), .pick_idx_o(idx), .pick_found_o(found),
    .pick_hit_o(hit), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // [39] policy [38:31] valid [30:23] hit [22:15] ready [14:7] mask
  // [6:4] idx [3] found [2] hit [1] early-req [0] spare
  localparam logic [39:0] CASES [12] = '{
    {1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'hFF, 8'h24, 8'hFF, 8'h00, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'hFB, 8'h24, 8'h00, 8'h00, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'hFF, 8'h00, 8'h50, 8'h00, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'hFF, 8'h00, 8'h00, 8'h88, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'hFF, 8'h00, 8'h40, 8'h02, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'hFF, 8'h80, 8'hFF, 8'h00, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'hFE, 8'h02, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'h7F, 8'h80, 8'h80, 8'h80, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'h80, 8'h80, 8'h00, 8'h00, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'hFF, 8'h01, 8'hFE, 8'hFE, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'hF0, 8'h00, 8'h0F, 8'h0F, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  // Entry i sits on rank i%2, bank i/2: flat bank (i%2)*8 + i/2, all distinct.
  task automatic setup(input logic [39:0] c);
    open_rows = '1;
    free_at   = '1;
    emask     = '0;
    policy    = c[39];
    valid     = c[38:31];
    for (int i = 0; i < N; i++) begin
      int fbk;
      fbk = (i % 2) * BPR + (i / 2);
      ranks[i*RANK_W +: RANK_W] = RANK_W'(i % 2);
      banks[i*BANK_W +: BANK_W] = BANK_W'(i / 2);
      rows[i*ROW_W +: ROW_W]    = ROW_W'(8'h40 + i);
      open_rows[fbk*ROW_W +: ROW_W] = c[23+i] ? ROW_W'(8'h40 + i) : ROW_W'(8'h80 + i);
      free_at[fbk*TIME_W +: TIME_W] = c[15+i] ? NOW : NOW + 16'd1;
      emask[fbk] = c[7+i];
    end
  endtask

  task automatic pulse_and_check(input string tag, input int e_idx, input int e_found,
                                 input int e_hit, input int e_req);
    start = 1'b1;
    #2;
    check({tag, " R8 early_req"}, int'(early_req), e_req);
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 done"}, int'(done), 1);
    check({tag, " idx"}, int'(idx), e_idx);
    check({tag, " found"}, int'(found), e_found);
    check({tag, " hit"}, int'(hit), e_hit);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset found", int'(found), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset idx", int'(idx), 0);
    check("R1 post-reset hit", int'(hit), 0);

    // Cases cover R3 R4 R5 R6 R7 R10 R11.
    for (int k = 0; k < 12; k++) begin
      logic [39:0] c;
      c = CASES[k];
      setup(c);
      @(negedge clk);
      pulse_and_check($sformatf("case%0d R3/R4/R5/R6/R7/R10/R11", k),
                      int'(c[6:4]), int'(c[3]), int'(c[2]), int'(c[1]));
    end

    // R2: outputs hold while start stays low.
    setup(CASES[1]);
    @(negedge clk);
    pulse_and_check("R2 prime", 2, 1, 1, 0);
    setup(CASES[3]);
    repeat (2) @(negedge clk);
    check("R2 hold idx", int'(idx), 2);
    check("R2 hold hit", int'(hit), 1);
    check("R2 no done", int'(done), 0);

    // R9: entry 0 on rank 1 bank 0 -> flat bank 8; other plausible banks carry other rows.
    setup(CASES[0]);
    valid = 8'h01;
    ranks[0 +: RANK_W] = 1'b1;
    banks[0 +: BANK_W] = 3'd0;
    rows[0 +: ROW_W]   = 8'h33;
    open_rows = '1;
    open_rows[8*ROW_W +: ROW_W] = 8'h33;
    open_rows[1*ROW_W +: ROW_W] = 8'h11;
    open_rows[2*ROW_W +: ROW_W] = 8'h22;
    open_rows[0*ROW_W +: ROW_W] = 8'h44;
    @(negedge clk);
    pulse_and_check("R9 flat bank", 0, 1, 1, 0);

    // R6 boundary: free exactly one past now is not free.
    setup(CASES[0]);
    free_at[((0 % 2) * BPR + 0)*TIME_W +: TIME_W] = NOW + 16'd1;
    free_at[((1 % 2) * BPR + 0)*TIME_W +: TIME_W] = NOW;
    @(negedge clk);
    pulse_and_check("R6 equal time", 1, 1, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule